// File: doc/BRIEF.md
# Serial Link Self-Test Pattern Generator

This block produces the test words that a transceiver sends over a serial link when the link tests itself. It has one parallel output that is 20 bits wide. A 3-bit mode input chooses what the block sends. There are two short pseudo-random sequences, one with 16-bit words and one with 20-bit words. There is a counting sequence that the block frames with control characters. There are also three constant bit patterns that give high, low and mixed toggle rates on the line.

The counting sequence leaves the block as bytes. Each byte has a flag that marks it as a control character. An 8b/10b encoder placed after the block turns these into line codes. The counting sequence can place one character or two characters in each output word. This block does no serialisation, no encoding and no clocking.

Every rising clock edge with the enable high is one word boundary. At each such edge the block registers one new output word. While the enable is low the output holds its value and every sequence stays where it is. At an enabled edge, a mode that differs from the last applied mode starts the newly selected sequence again from its first element. The output word of that same edge already holds that first element.

Top module: `lnk_bist_gen`

## Requirements
- R1: The reset input is synchronous and active high. After reset, `data_o` and `ctrl_o` are zero and the applied mode is idle (code 7). The first enabled edge after reset outputs the first element of the selected mode.
- R2: Mode 0 (16-bit pseudo-random) uses an 8-bit register that starts at all ones. Each bit step outputs state bit 7, then shifts left and feeds state bits 7^6^4^2 into bit 0 (x^8+x^7+x^5+x^3+1). One word is 16 such bits, the first bit in bit 0. Bits 19:16 and `ctrl_o` are zero. The word stream repeats every 255 words.
- R3: Mode 1 (20-bit pseudo-random) works the same way with a 10-bit all-ones register and feedback from state bits 9^6 (x^10+x^7+1). It makes 20 bits per word, the first bit in bit 0. `ctrl_o` is zero. The word stream repeats every 1023 words.
- R4: The counting sequence has 268 characters, in this order: K28.5, K27.7, data bytes 0x00 to 0xFF rising, then K28.0, K28.1, K28.2, K28.3, K28.4, K28.6, K28.7, K23.7, K30.7, K29.7. After the last character it starts again at K28.5. A control character Kx.y has the byte value (y<<5)|x and a flag of 1. Data bytes have a flag of 0.
- R5: Mode 2 puts one character in each word. The byte goes in `data_o[7:0]` and its flag goes in `ctrl_o[0]`. `data_o[19:8]` and `ctrl_o[1]` are zero.
- R6: Mode 3 puts two consecutive characters in each word. The earlier character goes in `data_o[7:0]` with its flag in `ctrl_o[0]`. The later character goes in `data_o[15:8]` with its flag in `ctrl_o[1]`. `data_o[19:16]` is zero.
- R7: Mode 4 outputs 0x002AA (1010101010) on every word. Mode 5 outputs 0x000F8 (0011111000) on every word. In both modes `ctrl_o` is zero.
- R8: Mode 6 alternates between 0x000FA (0011111010) and 0x00305 (1100000101) on every word, starting with 0x000FA. `ctrl_o` is zero.
- R9: While `en_i` is low, the outputs hold their values and the sequence position holds. A mode change while `en_i` is low has no effect until an enabled edge.
- R10: At an enabled edge where `mode_i` differs from the applied mode, the new mode starts from its first element in that edge's word. The next enabled edge continues from the second element.
- R11: Mode 7 (idle) outputs zero on `data_o` and `ctrl_o`.
- R12: A word produced in mode 0 or mode 1 is never all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one word per enabled rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 3 | Pattern select, codes 0 to 7 |
| en_i | input | 1 | Advance enable; when low, the output and the sequences hold |
| data_o | output | 20 | Registered output word |
| ctrl_o | output | 2 | Control-character flags for bytes 0 and 1 |

## Verification
A mode change and a sequence step can land on the same enabled edge. The block must then give up the old position, emit the first element of the new mode and advance to the second element, all in one cycle. A mode change with `en_i` low, followed by re-enabling, must not restart anything. The bench provokes both cases with directed switches in the middle of a sequence and with random stimulus that changes the mode now and then and drops the enable on about one edge in five. It judges every word against an independent bench model of all seven modes, which restarts only on enabled edges where the mode differs.

// File: rtl/lnk_bist_pkg.sv
package lnk_bist_pkg;

    localparam int WORD_W    = 20;
    localparam int BYTE_W    = 8;
    localparam int NFLAG     = 2;
    localparam int PAT_W     = 10;

    // counting sequence geometry
    localparam int SEQ_LEN    = 268;
    localparam int SEQ_IDX_W  = 9;
    localparam int HEAD_LEN   = 2;
    localparam int DATA_CNT   = 256;
    localparam int TAIL_START = HEAD_LEN + DATA_CNT;

    // fixed toggle patterns, bit 9 is the leftmost written bit
    localparam logic [PAT_W-1:0] PAT_HI    = 10'b1010101010;
    localparam logic [PAT_W-1:0] PAT_LO    = 10'b0011111000;
    localparam logic [PAT_W-1:0] PAT_MIX_A = 10'b0011111010;
    localparam logic [PAT_W-1:0] PAT_MIX_B = 10'b1100000101;

    typedef enum logic [2:0] {
        MODE_PRBS16  = 3'd0,
        MODE_PRBS20  = 3'd1,
        MODE_INC10   = 3'd2,
        MODE_INC20   = 3'd3,
        MODE_HIFREQ  = 3'd4,
        MODE_LOFREQ  = 3'd5,
        MODE_MIXFREQ = 3'd6,
        MODE_IDLE    = 3'd7
    } bist_mode_e;

    // a character: flag in bit 8, byte in bits 7:0
    typedef logic [BYTE_W:0] char_t;

    function automatic char_t kchar(input logic [4:0] x, input logic [2:0] y);
        return {1'b1, y, x};
    endfunction

    function automatic char_t seq_char(input logic [SEQ_IDX_W-1:0] idx);
        logic [SEQ_IDX_W-1:0] off;
        char_t                c;
        c = '0;
        if (idx == SEQ_IDX_W'(0)) begin
            c = kchar(5'd28, 3'd5);
        end else if (idx == SEQ_IDX_W'(1)) begin
            c = kchar(5'd27, 3'd7);
        end else if (idx < SEQ_IDX_W'(TAIL_START)) begin
            off = idx - SEQ_IDX_W'(HEAD_LEN);
            c   = {1'b0, off[BYTE_W-1:0]};
        end else begin
            off = idx - SEQ_IDX_W'(TAIL_START);
            case (off[3:0])
                4'd0:    c = kchar(5'd28, 3'd0);
                4'd1:    c = kchar(5'd28, 3'd1);
                4'd2:    c = kchar(5'd28, 3'd2);
                4'd3:    c = kchar(5'd28, 3'd3);
                4'd4:    c = kchar(5'd28, 3'd4);
                4'd5:    c = kchar(5'd28, 3'd6);
                4'd6:    c = kchar(5'd28, 3'd7);
                4'd7:    c = kchar(5'd23, 3'd7);
                4'd8:    c = kchar(5'd30, 3'd7);
                default: c = kchar(5'd29, 3'd7);
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/lnk_bist_prbs.sv
module lnk_bist_prbs #(
    parameter int                  LFSR_W = 8,
    parameter logic [LFSR_W-1:0]   TAPS   = 8'hD4,
    parameter int                  OUT_W  = 16,
    parameter int                  WORD_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              step,
    output logic [WORD_W-1:0] word
);

    localparam logic [LFSR_W-1:0] SEED = '1;

    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
    } prbs_st_t;

    prbs_st_t st_q, st_d;

    always_comb begin
        logic [LFSR_W-1:0] s;
        s    = restart ? SEED : st_q.lfsr;
        word = '0;
        for (int i = 0; i < OUT_W; i++) begin
            word[i] = s[LFSR_W-1];
            s       = {s[LFSR_W-2:0], ^(s & TAPS)};
        end
        st_d = st_q;
        if (step) begin
            st_d.lfsr = s;
        end else if (restart) begin
            st_d.lfsr = SEED;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.lfsr <= SEED;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lnk_bist_incr.sv
module lnk_bist_incr
    import lnk_bist_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    restart,
    input  logic                    step,
    input  logic                    wide,
    output logic [2*BYTE_W-1:0]     bytes,
    output logic [NFLAG-1:0]        flags
);

    localparam logic [SEQ_IDX_W-1:0] LAST = SEQ_IDX_W'(SEQ_LEN - 1);

    typedef struct packed {
        logic [SEQ_IDX_W-1:0] idx;
    } incr_st_t;

    incr_st_t st_q, st_d;

    logic [SEQ_IDX_W-1:0] cur, nxt1, nxt2;
    char_t                c0, c1;

    always_comb begin
        cur  = restart ? '0 : st_q.idx;
        nxt1 = (cur == LAST) ? '0 : cur + 1'b1;
        nxt2 = (nxt1 == LAST) ? '0 : nxt1 + 1'b1;
        c0   = seq_char(cur);
        c1   = seq_char(nxt1);
        if (wide) begin
            bytes = {c1[BYTE_W-1:0], c0[BYTE_W-1:0]};
            flags = {c1[BYTE_W], c0[BYTE_W]};
        end else begin
            bytes = {{BYTE_W{1'b0}}, c0[BYTE_W-1:0]};
            flags = {1'b0, c0[BYTE_W]};
        end
        st_d = st_q;
        if (step) begin
            st_d.idx = wide ? nxt2 : nxt1;
        end else if (restart) begin
            st_d.idx = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.idx <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lnk_bist_freq.sv
module lnk_bist_freq
    import lnk_bist_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              step,
    input  bist_mode_e        mode,
    output logic [PAT_W-1:0]  pat
);

    typedef struct packed {
        logic phase;
    } freq_st_t;

    freq_st_t st_q, st_d;
    logic     ph;

    always_comb begin
        ph = restart ? 1'b0 : st_q.phase;
        case (mode)
            MODE_HIFREQ:  pat = PAT_HI;
            MODE_LOFREQ:  pat = PAT_LO;
            MODE_MIXFREQ: pat = ph ? PAT_MIX_B : PAT_MIX_A;
            default:      pat = '0;
        endcase
        st_d = st_q;
        if (step) begin
            st_d.phase = ~ph;
        end else if (restart) begin
            st_d.phase = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.phase <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/lnk_bist_gen.sv
module lnk_bist_gen
    import lnk_bist_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        mode_i,
    input  logic              en_i,
    output logic [WORD_W-1:0] data_o,
    output logic [NFLAG-1:0]  ctrl_o
);

    localparam int P16_LFSR_W = 8;
    localparam int P16_OUT_W  = 16;
    localparam int P20_LFSR_W = 10;
    localparam int P20_OUT_W  = 20;
    localparam logic [P16_LFSR_W-1:0] P16_TAPS = 8'b1101_0100;     // bits 7,6,4,2
    localparam logic [P20_LFSR_W-1:0] P20_TAPS = 10'b10_0100_0000; // bits 9,6

    typedef struct packed {
        bist_mode_e          mode;
        logic [WORD_W-1:0]   data;
        logic [NFLAG-1:0]    ctrl;
    } top_st_t;

    top_st_t st_q, st_d;

    bist_mode_e           mode_sel;
    logic                 restart;
    logic                 step_p16, step_p20, step_inc, step_frq;
    logic [WORD_W-1:0]    p16_word, p20_word;
    logic [2*BYTE_W-1:0]  inc_bytes;
    logic [NFLAG-1:0]     inc_flags;
    logic [PAT_W-1:0]     frq_pat;

    always_comb begin
        mode_sel = bist_mode_e'(mode_i);
        restart  = en_i && (mode_sel != st_q.mode);
        step_p16 = en_i && (mode_sel == MODE_PRBS16);
        step_p20 = en_i && (mode_sel == MODE_PRBS20);
        step_inc = en_i && ((mode_sel == MODE_INC10) || (mode_sel == MODE_INC20));
        step_frq = en_i && ((mode_sel == MODE_HIFREQ) || (mode_sel == MODE_LOFREQ) ||
                            (mode_sel == MODE_MIXFREQ));
    end

    lnk_bist_prbs #(
        .LFSR_W (P16_LFSR_W),
        .TAPS   (P16_TAPS),
        .OUT_W  (P16_OUT_W),
        .WORD_W (WORD_W)
    ) u_prbs16 (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .step    (step_p16),
        .word    (p16_word)
    );

    lnk_bist_prbs #(
        .LFSR_W (P20_LFSR_W),
        .TAPS   (P20_TAPS),
        .OUT_W  (P20_OUT_W),
        .WORD_W (WORD_W)
    ) u_prbs20 (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .step    (step_p20),
        .word    (p20_word)
    );

    lnk_bist_incr u_incr (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .step    (step_inc),
        .wide    (mode_sel == MODE_INC20),
        .bytes   (inc_bytes),
        .flags   (inc_flags)
    );

    lnk_bist_freq u_freq (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .step    (step_frq),
        .mode    (mode_sel),
        .pat     (frq_pat)
    );

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            st_d.mode = mode_sel;
            st_d.ctrl = '0;
            case (mode_sel)
                MODE_PRBS16: st_d.data = p16_word;
                MODE_PRBS20: st_d.data = p20_word;
                MODE_INC10, MODE_INC20: begin
                    st_d.data = {{(WORD_W - 2*BYTE_W){1'b0}}, inc_bytes};
                    st_d.ctrl = inc_flags;
                end
                MODE_HIFREQ, MODE_LOFREQ, MODE_MIXFREQ:
                    st_d.data = {{(WORD_W - PAT_W){1'b0}}, frq_pat};
                default:     st_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mode <= MODE_IDLE;
            st_q.data <= '0;
            st_q.ctrl <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.data;
    assign ctrl_o = st_q.ctrl;

endmodule

// File: rtl/lnk_bist_gen_chk.sv
module lnk_bist_gen_chk
    import lnk_bist_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [2:0]        mode_i,
    input logic              en_i,
    input logic [WORD_W-1:0] data_o,
    input logic [NFLAG-1:0]  ctrl_o
);

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> ($stable(data_o) && $stable(ctrl_o)));

    assert_inc10_upper_R5: assert property (@(posedge clk) disable iff (rst)
        (en_i && mode_i == 3'(MODE_INC10)) |=> (data_o[19:8] == '0 && ctrl_o[1] == 1'b0));

    assert_inc20_upper_R6: assert property (@(posedge clk) disable iff (rst)
        (en_i && mode_i == 3'(MODE_INC20)) |=> (data_o[19:16] == '0));

    assert_hi_word_R7: assert property (@(posedge clk) disable iff (rst)
        (en_i && mode_i == 3'(MODE_HIFREQ)) |=> (data_o == 20'h002AA && ctrl_o == '0));

    assert_lo_word_R7: assert property (@(posedge clk) disable iff (rst)
        (en_i && mode_i == 3'(MODE_LOFREQ)) |=> (data_o == 20'h000F8 && ctrl_o == '0));

    assert_mix_a_to_b_R8: assert property (@(posedge clk) disable iff (rst)
        (en_i && mode_i == 3'(MODE_MIXFREQ) && $past(en_i && mode_i == 3'(MODE_MIXFREQ))
         && data_o == 20'h000FA) |=> (data_o == 20'h00305));

    assert_mix_b_to_a_R8: assert property (@(posedge clk) disable iff (rst)
        (en_i && mode_i == 3'(MODE_MIXFREQ) && $past(en_i && mode_i == 3'(MODE_MIXFREQ))
         && data_o == 20'h00305) |=> (data_o == 20'h000FA));

    assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
        (en_i && mode_i == 3'(MODE_IDLE)) |=> (data_o == '0 && ctrl_o == '0));

    assert_prbs_nonzero_R12: assert property (@(posedge clk) disable iff (rst)
        (en_i && (mode_i == 3'(MODE_PRBS16) || mode_i == 3'(MODE_PRBS20)))
        |=> (data_o != '0 && ctrl_o == '0));

endmodule

bind lnk_bist_gen lnk_bist_gen_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .mode_i (mode_i),
    .en_i   (en_i),
    .data_o (data_o),
    .ctrl_o (ctrl_o)
);

// File: tb/lnk_bist_gen_tb.sv
module lnk_bist_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    // mode codes as stated in the requirements
    localparam logic [2:0] M_P16 = 3'd0, M_P20 = 3'd1, M_I10 = 3'd2, M_I20 = 3'd3,
                           M_HI  = 3'd4, M_LO  = 3'd5, M_MIX = 3'd6, M_IDL = 3'd7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  mode_i = M_IDL;
    logic        en_i = 1'b0;
    logic [19:0] data_o;
    logic [1:0]  ctrl_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    // bench model
    logic [2:0]  m_mode;
    logic [7:0]  m_s8;
    logic [9:0]  m_s10;
    int          m_idx;
    bit          m_ph;
    logic [19:0] e_data;
    logic [1:0]  e_ctrl;

    always #(CLK_PERIOD/2) clk = ~clk;

    lnk_bist_gen u_dut (
        .clk    (clk),
        .rst    (rst),
        .mode_i (mode_i),
        .en_i   (en_i),
        .data_o (data_o),
        .ctrl_o (ctrl_o)
    );

    function automatic logic [19:0] p8_word(input logic [7:0] s_in);
        logic [7:0] s = s_in;
        logic [19:0] w = '0;
        for (int i = 0; i < 16; i++) begin
            w[i] = s[7];
            s = {s[6:0], s[7] ^ s[6] ^ s[4] ^ s[2]};
        end
        return w;
    endfunction

    function automatic logic [7:0] p8_next(input logic [7:0] s_in);
        logic [7:0] s = s_in;
        for (int i = 0; i < 16; i++) s = {s[6:0], s[7] ^ s[6] ^ s[4] ^ s[2]};
        return s;
    endfunction

    function automatic logic [19:0] p10_word(input logic [9:0] s_in);
        logic [9:0] s = s_in;
        logic [19:0] w = '0;
        for (int i = 0; i < 20; i++) begin
            w[i] = s[9];
            s = {s[8:0], s[9] ^ s[6]};
        end
        return w;
    endfunction

    function automatic logic [9:0] p10_next(input logic [9:0] s_in);
        logic [9:0] s = s_in;
        for (int i = 0; i < 20; i++) s = {s[8:0], s[9] ^ s[6]};
        return s;
    endfunction

    function automatic logic [8:0] kb(input int x, input int y);
        return {1'b1, 8'((y << 5) | x)};
    endfunction

    // R4 character list
    function automatic logic [8:0] exp_char(input int idx);
        if (idx == 0) return kb(28, 5);
        if (idx == 1) return kb(27, 7);
        if (idx < 258) return {1'b0, 8'(idx - 2)};
        case (idx - 258)
            0: return kb(28, 0);
            1: return kb(28, 1);
            2: return kb(28, 2);
            3: return kb(28, 3);
            4: return kb(28, 4);
            5: return kb(28, 6);
            6: return kb(28, 7);
            7: return kb(23, 7);
            8: return kb(30, 7);
            default: return kb(29, 7);
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] md);
        case (md)
            M_P16: return "R2";
            M_P20: return "R3";
            M_I10: return "R5";
            M_I20: return "R6";
            M_HI, M_LO: return "R7";
            M_MIX: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic model_reset();
        m_mode = M_IDL; m_s8 = 8'hFF; m_s10 = 10'h3FF; m_idx = 0; m_ph = 1'b0;
        e_data = '0; e_ctrl = '0;
    endtask

    task automatic model_edge(input logic [2:0] md);
        logic [8:0] c0, c1;
        if (md != m_mode) begin  // R10 restart
            m_mode = md; m_s8 = 8'hFF; m_s10 = 10'h3FF; m_idx = 0; m_ph = 1'b0;
        end
        e_ctrl = '0;
        case (md)
            M_P16: begin e_data = p8_word(m_s8); m_s8 = p8_next(m_s8); end
            M_P20: begin e_data = p10_word(m_s10); m_s10 = p10_next(m_s10); end
            M_I10: begin
                c0 = exp_char(m_idx);
                e_data = {12'h0, c0[7:0]}; e_ctrl = {1'b0, c0[8]};
                m_idx = (m_idx + 1) % 268;
            end
            M_I20: begin
                c0 = exp_char(m_idx); c1 = exp_char((m_idx + 1) % 268);
                e_data = {4'h0, c1[7:0], c0[7:0]}; e_ctrl = {c1[8], c0[8]};
                m_idx = (m_idx + 2) % 268;
            end
            M_HI:  e_data = 20'h002AA;
            M_LO:  e_data = 20'h000F8;
            M_MIX: begin e_data = m_ph ? 20'h00305 : 20'h000FA; m_ph = ~m_ph; end
            default: e_data = '0;
        endcase
    endtask

    task automatic check_word(input string tag);
        n_checks++;
        if (data_o !== e_data || ctrl_o !== e_ctrl) begin
            n_errors++;
            $display("FAIL %s: data/ctrl %h/%b expected %h/%b", tag, data_o, ctrl_o, e_data, e_ctrl);
        end
    endtask

    task automatic check_val(input string tag, input logic [21:0] act, input logic [21:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // one edge: drive at negedge, sample one step after the edge
    task automatic cycle(input logic e, input logic [2:0] md, input string tag);
        @(negedge clk);
        en_i = e; mode_i = md;
        if (e) model_edge(md);
        @(posedge clk);
        #1;
        check_word(tag == "" ? req_of(md) : tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; en_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(posedge clk);
        #1;
        check_word("R1");
    endtask

    task automatic finish_sim();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_sim();
    end

    initial begin
        logic [19:0] first;
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);
        model_reset();
        do_reset();

        // R1 / R2: first word after reset, period 255, never zero (R12)
        cycle(1'b1, M_P16, "R1");
        first = data_o;
        check_val("R1", {2'b0, data_o}, {2'b0, p8_word(8'hFF)});
        for (int i = 1; i < 256; i++) begin
            cycle(1'b1, M_P16, "");
            if (data_o == '0) check_val("R12", 22'(data_o), 22'h1);
        end
        check_val("R2", {2'b0, data_o}, {2'b0, first});

        // R3: period 1023
        cycle(1'b1, M_P20, "R10");
        first = data_o;
        for (int i = 1; i < 1024; i++) begin
            cycle(1'b1, M_P20, "");
            if (data_o == '0) check_val("R12", 22'(data_o), 22'h1);
        end
        check_val("R3", {2'b0, data_o}, {2'b0, first});

        // R4 / R5: full loop plus wrap
        for (int i = 0; i < 270; i++) begin
            cycle(1'b1, M_I10, "R4");
            if (i == 267) check_val("R4", {ctrl_o, data_o}, {2'b01, 20'h000FD});
            if (i == 268) check_val("R4", {ctrl_o, data_o}, {2'b01, 20'h000BC});
        end

        // R6: pairs, first word K27.7:K28.5
        cycle(1'b1, M_I20, "R6");
        check_val("R6", {ctrl_o, data_o}, {2'b11, 20'h0FBBC});
        for (int i = 0; i < 140; i++) cycle(1'b1, M_I20, "");

        // R9: hold with a pending mode change, then resume
        for (int i = 0; i < 5; i++) cycle(1'b1, M_I10, "R10");
        for (int i = 0; i < 4; i++) cycle(1'b0, M_HI, "R9");
        for (int i = 0; i < 3; i++) cycle(1'b1, M_I10, "R9");

        // R10: switch mid-sequence and back
        cycle(1'b1, M_P16, "R10");
        check_val("R10", {2'b0, data_o}, {2'b0, p8_word(8'hFF)});
        cycle(1'b1, M_I10, "R10");
        check_val("R10", {ctrl_o, data_o}, {2'b01, 20'h000BC});

        // R7, R8, R11
        for (int i = 0; i < 4; i++) cycle(1'b1, M_HI, "");
        for (int i = 0; i < 4; i++) cycle(1'b1, M_LO, "");
        cycle(1'b1, M_MIX, "R8");
        check_val("R8", {2'b0, data_o}, 22'h000FA);
        for (int i = 0; i < 7; i++) cycle(1'b1, M_MIX, "");
        for (int i = 0; i < 3; i++) cycle(1'b1, M_IDL, "");

        // constrained random: sticky modes, enable mostly high
        begin
            logic [2:0] md;
            md = M_I20;
            for (int i = 0; i < 5000; i++) begin
                if ($urandom_range(0, 49) == 0) md = 3'($urandom_range(0, 7));
                cycle(($urandom_range(0, 4) != 0), md, "");
            end
        end

        // R1: reset in mid-run
        cycle(1'b1, M_I10, "");
        do_reset();
        cycle(1'b1, M_MIX, "R1");

        finish_sim();
    end

endmodule